// File: doc/BRIEF.md
# Remote Configuration Update Sequencer

This block runs once after reset is released. It steers the parameter read and write handshake of a remote-reconfiguration engine, the logic that chooses which image the device loads from its configuration flash. First it waits for the engine to finish its own power-up work, which the engine signals by dropping busy. It then waits a further settle interval, because the engine returns the invalid all-ones trigger value 5'h1F if it is read too early. After that it reads the trigger-conditions parameter to learn why the device was last configured.

A zero trigger means a plain power-on configuration. In that case the sequencer programs the application image boot address, the watchdog timeout and the watchdog enable, then sets the application-not-factory bit, and finally requests a reconfiguration. Any other trigger, such as a watchdog timeout, means a fallback has already happened. The sequencer then parks in a terminal idle state and stays there, so the device keeps running the factory image. Each access keeps its strobe asserted until the engine has raised busy and dropped it again.

Top module: `cfg_update_seq`

## Requirements
- R1: While reset is asserted, and until the sequencer acts, rd_strobe, wr_strobe, reconfig_req, stat_reconf and stat_idle are low and stat_trig is zero.
- R2: The sequencer makes no parameter access until the engine's busy has first been seen low. It then waits at least DELAY_CYCLES clock cycles, and no more than three cycles beyond that, before the first read strobe.
- R3: The first access is a single read with param_sel = 3'b000, the trigger-conditions code. The trigger is taken from bits [4:0] of rd_data.
- R4: A nonzero trigger moves the sequencer to the terminal state 5'b11111 on seq_state. In that state it issues no further strobe and no reconfig_req.
- R5: A strobe stays asserted until the engine has raised busy and then dropped it. The strobe is released on the clock edge that samples busy low after that rise.
- R6: rd_strobe and wr_strobe are never high together. param_sel and wr_data stay stable while a strobe is held.
- R7: A zero trigger produces exactly four writes in this order: code 3'b100 with BOOT_ADDR, code 3'b010 with WD_TIMEOUT, code 3'b011 with WD_ENABLE, and code 3'b101 with data 1 (application-not-factory). Each write uses its own strobe, with at least one low cycle between writes. seq_state lies within 5'b00100 to 5'b01100 during a write.
- R8: One cycle after the gap that follows the last write, reconfig_req is high for exactly one cycle. seq_state then holds 5'b01101.
- R9: stat_trig holds the captured trigger. stat_reconf is high only once a reconfiguration has been requested. stat_idle is high only in the terminal idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| eng_busy | input | 1 | Engine busy flag |
| rd_data | input | DW | Parameter value returned by the engine |
| rd_strobe | output | 1 | Parameter read request, held through the busy cycle |
| wr_strobe | output | 1 | Parameter write request, held through the busy cycle |
| param_sel | output | 3 | Parameter code for the current access |
| wr_data | output | DW | Value for the current write |
| reconfig_req | output | 1 | One-cycle reconfiguration request |
| stat_trig | output | 5 | Captured trigger value |
| stat_reconf | output | 1 | Reconfiguration was requested |
| stat_idle | output | 1 | Idle path taken |
| seq_state | output | 5 | Current state code |

## Verification
The bench's engine model returns 5'h1F for any read made before the settle interval has elapsed. A sequencer that reads too early therefore takes the idle path on a power-on run, and the missing writes and missing reconfiguration show it up. The model also varies both its response latency and the length of its busy pulse. A design that pulses the strobe for one cycle, or releases it on the rising edge of busy, drops the strobe outside the model's completion phase. Power-up busy lengths, including zero, test the first-low detection. Nonzero triggers, including the invalid value, confirm that the idle state is terminal and that no write leaks out.

// File: rtl/cfg_update_pkg.sv
package cfg_update_pkg;
  typedef enum logic [4:0] {
    ST_BOOT   = 5'b00000,
    ST_SETTLE = 5'b00001,
    ST_READ   = 5'b00010,
    ST_EVAL   = 5'b00011,
    ST_W_ADDR = 5'b00100,
    ST_GAP0   = 5'b00101,
    ST_W_WDT  = 5'b00110,
    ST_GAP1   = 5'b00111,
    ST_W_WDEN = 5'b01000,
    ST_GAP2   = 5'b01001,
    ST_W_ANF  = 5'b01010,
    ST_GAP3   = 5'b01011,
    ST_PULSE  = 5'b01100,
    ST_DONE   = 5'b01101,
    ST_IDLE   = 5'b11111
  } seq_state_t;

  localparam logic [2:0] SEL_TRIG = 3'b000;
  localparam logic [2:0] SEL_WDT  = 3'b010;
  localparam logic [2:0] SEL_WDEN = 3'b011;
  localparam logic [2:0] SEL_ADDR = 3'b100;
  localparam logic [2:0] SEL_ANF  = 3'b101;
  localparam int unsigned TRIG_W = 5;
endpackage

// File: rtl/cfg_settle_timer.sv
module cfg_settle_timer #(
  parameter int unsigned DELAY_CYCLES = 50000
) (
  input  logic clk,
  input  logic srst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(DELAY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == LAST);
  assign cnt_en  = clr | (run & ~expired);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfg_access_track.sv
module cfg_access_track (
  input  logic clk,
  input  logic srst_n,
  input  logic active,
  input  logic busy,
  output logic done
);
  logic seen_q, seen_d, seen_en;

  assign done    = active & seen_q & ~busy;
  assign seen_en = ~active | busy;

  always_comb begin
    seen_d = seen_q;
    if (!active)   seen_d = 1'b0;
    else if (busy) seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      seen_q <= 1'b0;
    else if (seen_en) seen_q <= seen_d;
  end
endmodule

// File: rtl/cfg_update_seq.sv
module cfg_update_seq
  import cfg_update_pkg::*;
#(
  parameter int unsigned DW           = 32,
  parameter int unsigned DELAY_CYCLES = 50000,
  parameter logic [DW-1:0] BOOT_ADDR  = 32'h0100_0000,
  parameter logic [DW-1:0] WD_TIMEOUT = 32'h0000_0FFF,
  parameter logic [DW-1:0] WD_ENABLE  = 32'h0000_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eng_busy,
  input  logic [DW-1:0] rd_data,
  output logic          rd_strobe,
  output logic          wr_strobe,
  output logic [2:0]    param_sel,
  output logic [DW-1:0] wr_data,
  output logic          reconfig_req,
  output logic [4:0]    stat_trig,
  output logic          stat_reconf,
  output logic          stat_idle,
  output logic [4:0]    seq_state
);
  logic [1:0]  rsync_q;
  logic        srst_n;
  seq_state_t  state_q, state_d;
  logic        acc_active, acc_done, settle_done;
  logic [TRIG_W-1:0] trig_q;
  logic        trig_en, flag_q, flag_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  assign rd_strobe  = (state_q == ST_READ);
  assign wr_strobe  = (state_q == ST_W_ADDR) | (state_q == ST_W_WDT) |
                      (state_q == ST_W_WDEN) | (state_q == ST_W_ANF);
  assign acc_active = rd_strobe | wr_strobe;

  cfg_settle_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk(clk), .srst_n(srst_n),
    .clr(state_q == ST_BOOT), .run(state_q == ST_SETTLE),
    .expired(settle_done)
  );

  cfg_access_track u_track (
    .clk(clk), .srst_n(srst_n),
    .active(acc_active), .busy(eng_busy), .done(acc_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_BOOT:   if (!eng_busy)   state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_d = ST_READ;
      ST_READ:   if (acc_done)    state_d = ST_EVAL;
      ST_EVAL:   state_d = (trig_q == '0) ? ST_W_ADDR : ST_IDLE;
      ST_W_ADDR: if (acc_done)    state_d = ST_GAP0;
      ST_GAP0:   state_d = ST_W_WDT;
      ST_W_WDT:  if (acc_done)    state_d = ST_GAP1;
      ST_GAP1:   state_d = ST_W_WDEN;
      ST_W_WDEN: if (acc_done)    state_d = ST_GAP2;
      ST_GAP2:   state_d = ST_W_ANF;
      ST_W_ANF:  if (acc_done)    state_d = ST_GAP3;
      ST_GAP3:   state_d = ST_PULSE;
      ST_PULSE:  state_d = ST_DONE;
      ST_DONE:   state_d = ST_DONE;
      ST_IDLE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= ST_BOOT;
    else         state_q <= state_d;
  end

  assign trig_en = rd_strobe & acc_done;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      trig_q <= '0;
    else if (trig_en) trig_q <= rd_data[TRIG_W-1:0];
  end

  assign flag_en = (state_q == ST_PULSE);
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= 1'b1;
  end

  always_comb begin
    param_sel = SEL_TRIG;
    wr_data   = '0;
    unique case (state_q)
      ST_W_ADDR: begin param_sel = SEL_ADDR; wr_data = BOOT_ADDR;  end
      ST_W_WDT:  begin param_sel = SEL_WDT;  wr_data = WD_TIMEOUT; end
      ST_W_WDEN: begin param_sel = SEL_WDEN; wr_data = WD_ENABLE;  end
      ST_W_ANF:  begin param_sel = SEL_ANF;  wr_data = DW'(1);     end
      default:   ;
    endcase
  end

  assign reconfig_req = (state_q == ST_PULSE);
  assign stat_trig    = trig_q;
  assign stat_reconf  = flag_q;
  assign stat_idle    = (state_q == ST_IDLE);
  assign seq_state    = state_q;
endmodule

// File: rtl/cfg_update_seq_chk.sv
module cfg_update_seq_chk #(
  parameter int unsigned DW           = 32,
  parameter int unsigned DELAY_CYCLES = 50000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_busy,
  input logic          rd_strobe,
  input logic          wr_strobe,
  input logic [2:0]    param_sel,
  input logic [DW-1:0] wr_data,
  input logic          reconfig_req,
  input logic [4:0]    stat_trig,
  input logic          stat_idle,
  input logic [4:0]    seq_state
);
  localparam int unsigned CW = $clog2(DELAY_CYCLES + 1) + 1;
  logic          low_seen_q;
  logic [CW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_seen_q <= 1'b0;
      since_q    <= '0;
    end else begin
      if (!eng_busy) low_seen_q <= 1'b1;
      if (low_seen_q && since_q < CW'(DELAY_CYCLES)) since_q <= since_q + 1'b1;
    end
  end

  p_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> (low_seen_q && since_q >= CW'(DELAY_CYCLES)));

  p_first_read_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> (param_sel == 3'b000));

  p_idle_terminal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_idle |=> (stat_idle && !rd_strobe && !wr_strobe && !reconfig_req));

  p_hold_until_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_strobe) || $fell(wr_strobe)) |-> !$past(eng_busy));

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe));

  p_write_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && $past(wr_strobe)) |-> ($stable(param_sel) && $stable(wr_data)));

  p_write_states_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (seq_state >= 5'b00100 && seq_state <= 5'b01100));

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_req |=> (!reconfig_req && seq_state == 5'b01101));

  p_reconf_zero_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_req |-> (stat_trig == 5'd0));
endmodule

bind cfg_update_seq cfg_update_seq_chk #(.DW(DW), .DELAY_CYCLES(DELAY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy),
  .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .param_sel(param_sel),
  .wr_data(wr_data), .reconfig_req(reconfig_req), .stat_trig(stat_trig),
  .stat_idle(stat_idle), .seq_state(seq_state)
);

// File: tb/test_cfg_update_seq.sv
module test_cfg_update_seq;
  localparam int unsigned DW = 32;
  localparam int unsigned D  = 64;
  localparam logic [DW-1:0] P_ADDR = 32'h0123_4000;
  localparam logic [DW-1:0] P_WDT  = 32'h0000_02A5;
  localparam logic [DW-1:0] P_WDEN = 32'h0000_0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eng_busy;
  logic [DW-1:0] rd_data;
  logic rd_strobe, wr_strobe, reconfig_req, stat_reconf, stat_idle;
  logic [2:0] param_sel;
  logic [DW-1:0] wr_data;
  logic [4:0] stat_trig, seq_state;

  always #2 clk = ~clk;

  cfg_update_seq #(.DW(DW), .DELAY_CYCLES(D), .BOOT_ADDR(P_ADDR),
                   .WD_TIMEOUT(P_WDT), .WD_ENABLE(P_WDEN)) i_cfg_update_seq (
    .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .rd_data(rd_data),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .param_sel(param_sel),
    .wr_data(wr_data), .reconfig_req(reconfig_req), .stat_trig(stat_trig),
    .stat_reconf(stat_reconf), .stat_idle(stat_idle), .seq_state(seq_state));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // engine model
  localparam int M_INIT = 0, M_IDLE = 1, M_LAT = 2, M_BUSY = 3, M_DROP = 4;
  int mph, init_cnt, init_len, lat, bz, since_low;
  bit acc_rd;
  logic [4:0] trig_cfg;
  int nrd, nwr, first_sel;
  logic [2:0] log_sel [8];
  logic [DW-1:0] log_data [8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_busy <= 1'b1; init_cnt <= 0; mph <= M_INIT; since_low <= 0;
      rd_data <= '0; lat <= 0; bz <= 0; acc_rd <= 1'b0;
    end else begin
      if (mph != M_INIT && since_low < 100000) since_low <= since_low + 1;
      case (mph)
        M_INIT: if (init_cnt >= init_len) begin eng_busy <= 1'b0; mph <= M_IDLE; end
                else init_cnt <= init_cnt + 1;
        M_IDLE: if (rd_strobe || wr_strobe) begin
                  lat <= 1 + int'($urandom % 3); bz <= 1 + int'($urandom % 5);
                  acc_rd <= rd_strobe; mph <= M_LAT;
                  if (rd_strobe) begin
                    if (nrd == 0) first_sel <= int'(param_sel);
                    nrd <= nrd + 1;
                  end else begin
                    if (nwr < 8) begin log_sel[nwr] <= param_sel; log_data[nwr] <= wr_data; end
                    nwr <= nwr + 1;
                  end
                end
        M_LAT:  if (lat <= 1) begin eng_busy <= 1'b1; mph <= M_BUSY; end
                else lat <= lat - 1;
        M_BUSY: if (bz <= 1) begin
                  eng_busy <= 1'b0; mph <= M_DROP;
                  rd_data <= acc_rd ? ((since_low < D) ? 32'h1F : {27'd0, trig_cfg}) : '0;
                end else bz <= bz - 1;
        default: if (!rd_strobe && !wr_strobe) mph <= M_IDLE;
      endcase
    end
  end

  // monitor, sampled away from the active edge
  longint cyc = 0, first_low = -1, rd_rise = -1;
  int pulses, max_pw, pw, hold_err, both_err, stab_err;
  logic prv_rd, prv_wr;
  logic [2:0] prv_sel;
  logic [DW-1:0] prv_data;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (!eng_busy && first_low < 0) first_low <= cyc;
      if (rd_strobe && !prv_rd && rd_rise < 0) rd_rise <= cyc;
      if (reconfig_req) begin pw = pw + 1; if (pw == 1) pulses <= pulses + 1; if (pw > max_pw) max_pw <= pw; end
      else pw = 0;
      if (((prv_rd && !rd_strobe) || (prv_wr && !wr_strobe)) && mph != M_DROP) hold_err <= hold_err + 1;
      if (rd_strobe && wr_strobe) both_err <= both_err + 1;
      if (wr_strobe && prv_wr && (param_sel != prv_sel || wr_data != prv_data)) stab_err <= stab_err + 1;
    end
    prv_rd <= rd_strobe; prv_wr <= wr_strobe; prv_sel <= param_sel; prv_data <= wr_data;
  end

  task automatic run_case(input logic [4:0] trig, input int ilen);
    logic [DW-1:0] exp_d [4];
    logic [2:0] exp_s [4];
    exp_s = '{3'b100, 3'b010, 3'b011, 3'b101};
    exp_d = '{P_ADDR, P_WDT, P_WDEN, 32'd1};
    rst_n = 1'b0;
    trig_cfg = trig; init_len = ilen;
    nrd = 0; nwr = 0; first_sel = -1; first_low = -1; rd_rise = -1;
    pulses = 0; max_pw = 0; pw = 0; hold_err = 0; both_err = 0; stab_err = 0;
    repeat (3) @(negedge clk);
    chk(!rd_strobe && !wr_strobe && !reconfig_req && !stat_reconf && !stat_idle && stat_trig == 0,
        "R1", "reset outputs", {rd_strobe, wr_strobe, reconfig_req, stat_reconf, stat_idle, stat_trig}, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (stat_idle || seq_state == 5'b01101) break;
    end
    repeat (40) @(negedge clk);
    chk(rd_rise - first_low >= D && rd_rise - first_low <= D + 3, "R2", "settle gap",
        rd_rise - first_low, D);
    chk(nrd == 1 && first_sel == 0, "R3", "single read of code 0", {nrd, first_sel}, {32'd1, 32'd0});
    chk(hold_err == 0, "R5", "strobe released before busy cycle ended", hold_err, 0);
    chk(both_err == 0 && stab_err == 0, "R6", "strobe exclusivity and stability",
        both_err + stab_err, 0);
    chk(stat_trig == trig, "R9", "captured trigger", stat_trig, trig);
    if (trig == 0) begin
      chk(nwr == 4, "R7", "write count", nwr, 4);
      for (int k = 0; k < 4; k++)
        chk(log_sel[k] == exp_s[k] && log_data[k] == exp_d[k], "R7", $sformatf("write %0d", k),
            {log_sel[k], log_data[k]}, {exp_s[k], exp_d[k]});
      chk(pulses == 1 && max_pw == 1, "R8", "reconfig pulse", {pulses, max_pw}, {32'd1, 32'd1});
      chk(seq_state == 5'b01101, "R8", "done state", seq_state, 5'b01101);
      chk(stat_reconf && !stat_idle, "R9", "reconf flag", {stat_reconf, stat_idle}, 2'b10);
    end else begin
      chk(seq_state == 5'b11111, "R4", "idle state", seq_state, 5'b11111);
      chk(nwr == 0 && pulses == 0 && !rd_strobe && !wr_strobe, "R4", "no activity when idle",
          {nwr, pulses}, 0);
      chk(!stat_reconf && stat_idle, "R9", "idle flag", {stat_reconf, stat_idle}, 2'b01);
    end
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = int'($urandom(32'h5EED));
    run_case(5'd0, 5);
    run_case(5'd2, 12);
    run_case(5'h1F, 0);
    run_case(5'd0, 0);
    for (int r = 0; r < 8; r++) begin
      logic [4:0] t;
      t = (r % 2 == 0) ? 5'd0 : 5'($urandom % 32);
      run_case(t, int'($urandom % 20));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule